// File: doc/BRIEF.md
# MM:SS Countdown Timer

A countdown timer that keeps a time of up to 59:59 as four BCD digits and is split into a datapath and a control unit. The datapath holds two two-digit BCD modulo-60 counters, one for seconds and one for minutes. Seconds borrow into minutes when counting down. A 2-to-1 selector decides which clock-enable advances them: the 20 Hz setting tick while the user adjusts the time, or the 1 Hz counting tick while the timer runs.

The user sets the time with two held buttons: one steps the minutes and one steps the seconds, both counting up. A start button, cleaned to one pulse per press, begins the countdown. When the count reaches 00:00 the block raises an alarm LED and passes an external tone waveform to its tone output. Both stay active until the stop button is pressed. The clock generator and the display driver sit outside the block. Both ticks arrive as single-cycle enables in the system clock domain, and all buttons are assumed to be already synchronised and debounced.

Top module: `mmss_timer`

## Requirements
- R1: After reset the four digits read 00:00, alarm_led is 0, tone_out is 0 and the block is in the setting state.
- R2: In the setting state, each cycle with tick_set high and btn_min high adds one to the minutes. 59 wraps to 00, and the seconds are unchanged.
- R3: In the setting state, each cycle with tick_set high and btn_sec high adds one to the seconds. 59 wraps to 00 with no carry into the minutes.
- R4: btn_start is reduced to a single pulse per press, however long it is held. That pulse moves the block into the running state if the time is not 00:00. At 00:00 the pulse has no effect and the block stays in the setting state.
- R5: In the running state, each cycle with tick_run high subtracts one second. Seconds at 00 become 59 and the minutes drop by one. tick_set, btn_min, btn_sec, btn_start and btn_stop do not change the count.
- R6: One cycle after the running count shows 00:00, alarm_led rises. The count then stays at 00:00 and never wraps to 59:59.
- R7: tone_out equals tone_in while alarm_led is 1 and is 0 otherwise.
- R8: btn_stop in the alarm state clears alarm_led on the next cycle and returns the block to the setting state, where the set buttons work again.
- R9: Every digit is valid BCD. The tens digits never exceed 5 and the units digits never exceed 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_set | input | 1 | 20 Hz setting enable, one cycle wide |
| tick_run | input | 1 | 1 Hz counting enable, one cycle wide |
| btn_min | input | 1 | Minute set button, level |
| btn_sec | input | 1 | Second set button, level |
| btn_start | input | 1 | Start button, level |
| btn_stop | input | 1 | Alarm stop button, level |
| tone_in | input | 1 | Audio tone waveform to be gated |
| min_tens | output | 4 | Minutes tens digit, BCD |
| min_ones | output | 4 | Minutes units digit, BCD |
| sec_tens | output | 4 | Seconds tens digit, BCD |
| sec_ones | output | 4 | Seconds units digit, BCD |
| alarm_led | output | 1 | Alarm indicator |
| tone_out | output | 1 | Gated tone |

## Verification
The bench drives the seconds through a full 59-to-00 wrap. A design that carried into the minutes there, or that stepped 09 to 0A, would show the wrong digits. It counts a run from 01:02 through the 00→59 borrow and on to zero. A design that wrapped to 59:59 or raised the alarm a cycle early or late would diverge from the cycle model. It also presses start at 00:00, holds start over several cycles, and wiggles set buttons and stop outside their states. These cases catch a design that runs from zero, restarts on a held button, or lets stray buttons move the count.

// File: rtl/mmss_pkg.sv
// Shared types and sizes for the MM:SS countdown timer.
// Assumes four-bit BCD digits and a modulo-60 field for minutes and seconds.
package mmss_pkg;
    localparam int DIGIT_W  = 4;
    localparam int TENS_TOP = 5;
    localparam int ONES_TOP = 9;

    typedef enum logic [1:0] {
        ST_SET   = 2'd0,
        ST_RUN   = 2'd1,
        ST_ALARM = 2'd2
    } tmr_state_t;

    typedef enum logic [1:0] {
        SY_WAIT_PRESS   = 2'd0,
        SY_PULSE        = 2'd1,
        SY_WAIT_RELEASE = 2'd2
    } sync_state_t;
endpackage

// File: rtl/bcd_mod60.sv
// Two-digit BCD counter with an up and a down step.
// Counts 00..(TENS_TOP)(ONES_TOP) and wraps in both directions.
// Assumes inc and dec are never high together; inc wins if they are.
module bcd_mod60 #(
    parameter int W        = 4,
    parameter int TENS_TOP = 5,
    parameter int ONES_TOP = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] tens,
    output logic [W-1:0] ones,
    output logic         at_zero
);
    localparam logic [W-1:0] T_MAX = W'(TENS_TOP);
    localparam logic [W-1:0] O_MAX = W'(ONES_TOP);

    logic [W-1:0] tens_q, ones_q;

    // Digit registers: step up or down with BCD wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tens_q <= '0;
            ones_q <= '0;
        end else if (inc) begin
            if (ones_q == O_MAX) begin
                ones_q <= '0;
                tens_q <= (tens_q == T_MAX) ? '0 : tens_q + 1'b1;
            end else begin
                ones_q <= ones_q + 1'b1;
            end
        end else if (dec) begin
            if (ones_q == '0) begin
                ones_q <= O_MAX;
                tens_q <= (tens_q == '0) ? T_MAX : tens_q - 1'b1;
            end else begin
                ones_q <= ones_q - 1'b1;
            end
        end
    end

    assign tens    = tens_q;
    assign ones    = ones_q;
    assign at_zero = (tens_q == '0) && (ones_q == '0);
endmodule

// File: rtl/start_sync.sv
// Three-state press detector: one-cycle pulse per press of a level button.
// Assumes the button is already synchronous to clk and debounced.
module start_sync
    import mmss_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic btn,
    output logic pulse
);
    sync_state_t st_q, st_d;

    // Next-state logic: wait for press, pulse once, wait for release.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SY_WAIT_PRESS:   if (btn)  st_d = SY_PULSE;
            SY_PULSE:        st_d = btn ? SY_WAIT_RELEASE : SY_WAIT_PRESS;
            SY_WAIT_RELEASE: if (!btn) st_d = SY_WAIT_PRESS;
            default:         st_d = SY_WAIT_PRESS;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SY_WAIT_PRESS;
        else        st_q <= st_d;
    end

    assign pulse = (st_q == SY_PULSE);
endmodule

// File: rtl/mmss_ctrl.sv
// Control unit: setting, running and alarm states of the timer.
// Assumes start_pulse is one cycle wide and time_zero reflects the datapath.
module mmss_ctrl
    import mmss_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_pulse,
    input  logic       stop,
    input  logic       time_zero,
    output tmr_state_t state
);
    tmr_state_t st_q, st_d;

    // Transitions: start from a nonzero time, alarm at zero, stop to clear.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_SET:   if (start_pulse && !time_zero) st_d = ST_RUN;
            ST_RUN:   if (time_zero)                 st_d = ST_ALARM;
            ST_ALARM: if (stop)                      st_d = ST_SET;
            default:  st_d = ST_SET;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_SET;
        else        st_q <= st_d;
    end

    assign state = st_q;
endmodule

// File: rtl/mmss_timer.sv
// MM:SS countdown timer top: datapath of two BCD modulo-60 counters plus
// the control unit. Assumes tick_set and tick_run are single-cycle enables
// and all buttons are synchronous and debounced.
module mmss_timer
    import mmss_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_set,
    input  logic               tick_run,
    input  logic               btn_min,
    input  logic               btn_sec,
    input  logic               btn_start,
    input  logic               btn_stop,
    input  logic               tone_in,
    output logic [DIGIT_W-1:0] min_tens,
    output logic [DIGIT_W-1:0] min_ones,
    output logic [DIGIT_W-1:0] sec_tens,
    output logic [DIGIT_W-1:0] sec_ones,
    output logic               alarm_led,
    output logic               tone_out
);
    tmr_state_t state;
    logic start_pulse, sec_zero, min_zero, time_zero;
    logic step_en, in_set, in_run, run_step;
    logic sec_inc, min_inc, sec_dec, min_dec;

    start_sync i_start (
        .clk   (clk),
        .rst_n (rst_n),
        .btn   (btn_start),
        .pulse (start_pulse)
    );

    mmss_ctrl i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_pulse (start_pulse),
        .stop        (btn_stop),
        .time_zero   (time_zero),
        .state       (state)
    );

    assign in_set = (state == ST_SET);
    assign in_run = (state == ST_RUN);

    // Tick selector: counting enable while running, setting enable otherwise.
    always_comb begin
        step_en = in_run ? tick_run : tick_set;
    end

    assign time_zero = sec_zero && min_zero;
    assign run_step  = in_run && step_en && !time_zero;
    assign sec_inc   = in_set && step_en && btn_sec;
    assign min_inc   = in_set && step_en && btn_min;
    assign sec_dec   = run_step;
    assign min_dec   = run_step && sec_zero;

    bcd_mod60 #(.W(DIGIT_W), .TENS_TOP(TENS_TOP), .ONES_TOP(ONES_TOP)) i_sec (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (sec_inc),
        .dec     (sec_dec),
        .tens    (sec_tens),
        .ones    (sec_ones),
        .at_zero (sec_zero)
    );

    bcd_mod60 #(.W(DIGIT_W), .TENS_TOP(TENS_TOP), .ONES_TOP(ONES_TOP)) i_min (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (min_inc),
        .dec     (min_dec),
        .tens    (min_tens),
        .ones    (min_ones),
        .at_zero (min_zero)
    );

    assign alarm_led = (state == ST_ALARM);
    assign tone_out  = alarm_led && tone_in;
endmodule

// File: rtl/mmss_timer_checker.sv
// Property checker for mmss_timer, attached by bind below.
// Observes top-level ports only.
module mmss_timer_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_set,
    input logic       tick_run,
    input logic       btn_stop,
    input logic [3:0] min_tens,
    input logic [3:0] min_ones,
    input logic [3:0] sec_tens,
    input logic [3:0] sec_ones,
    input logic       alarm_led,
    input logic       tone_out
);
    logic [15:0] digits;
    assign digits = {min_tens, min_ones, sec_tens, sec_ones};

    // R9: digits stay within BCD modulo-60 range
    a_r9_bcd_range: assert property (@(posedge clk) disable iff (!rst_n)
        (min_tens <= 4'd5) && (sec_tens <= 4'd5) && (min_ones <= 4'd9) && (sec_ones <= 4'd9));

    // R7: tone only passes while the alarm is on
    a_r7_tone_gated: assert property (@(posedge clk) disable iff (!rst_n)
        tone_out |-> alarm_led);

    // R6: the alarm holds the count at 00:00
    a_r6_alarm_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_led |-> (digits == 16'h0000));

    // R5: without any tick the count cannot move
    a_r5_no_tick_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_set && !tick_run) |=> $stable(digits));

    // R8: stop during alarm clears it on the next cycle
    a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_led && btn_stop) |=> !alarm_led);
endmodule

bind mmss_timer mmss_timer_checker i_mmss_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_set  (tick_set),
    .tick_run  (tick_run),
    .btn_stop  (btn_stop),
    .min_tens  (min_tens),
    .min_ones  (min_ones),
    .sec_tens  (sec_tens),
    .sec_ones  (sec_ones),
    .alarm_led (alarm_led),
    .tone_out  (tone_out)
);

// File: tb/test_mmss_timer.sv
`timescale 1ns/1ps
// Bench for mmss_timer: behavioural cycle model compared on every clock,
// plus directed checks at scenario boundaries.
module test_mmss_timer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_set = 0, tick_run = 0, btn_min = 0, btn_sec = 0;
    logic btn_start = 0, btn_stop = 0, tone_in = 0;
    logic [3:0] min_tens, min_ones, sec_tens, sec_ones;
    logic alarm_led, tone_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mmss_timer i_mmss_timer (
        .clk(clk), .rst_n(rst_n), .tick_set(tick_set), .tick_run(tick_run),
        .btn_min(btn_min), .btn_sec(btn_sec), .btn_start(btn_start),
        .btn_stop(btn_stop), .tone_in(tone_in),
        .min_tens(min_tens), .min_ones(min_ones), .sec_tens(sec_tens),
        .sec_ones(sec_ones), .alarm_led(alarm_led), .tone_out(tone_out)
    );

    // Reference model: mode 0 set, 1 run, 2 alarm; press 0 wait, 1 pulse, 2 held.
    int m_min = 0, m_sec = 0, m_mode = 0, m_press = 0;

    always @(posedge clk) begin
        int nmin, nsec, nmode, npress, total;
        if (!rst_n) begin
            m_min = 0; m_sec = 0; m_mode = 0; m_press = 0;
        end else begin
            nmin = m_min; nsec = m_sec; nmode = m_mode;
            case (m_mode)
                0: begin
                    if (tick_set && btn_min) nmin = (m_min + 1) % 60;
                    if (tick_set && btn_sec) nsec = (m_sec + 1) % 60;
                    if (m_press == 1 && (m_min + m_sec) != 0) nmode = 1;
                end
                1: begin
                    total = m_min * 60 + m_sec;
                    if (total == 0) nmode = 2;
                    else if (tick_run) begin
                        total = total - 1;
                        nmin = total / 60;
                        nsec = total % 60;
                    end
                end
                default: if (btn_stop) nmode = 0;
            endcase
            case (m_press)
                0: npress = btn_start ? 1 : 0;
                1: npress = btn_start ? 2 : 0;
                default: npress = btn_start ? 2 : 0;
            endcase
            m_min = nmin; m_sec = nsec; m_mode = nmode; m_press = npress;
        end
    end

    function automatic logic [15:0] enc(int mn, int sc);
        return {4'(mn / 10), 4'(mn % 10), 4'(sc / 10), 4'(sc % 10)};
    endfunction

    function automatic string tag_of(int mode);
        return (mode == 0) ? "R2/R3" : (mode == 1) ? "R5" : "R6";
    endfunction

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            n_checks++;
            if ({min_tens, min_ones, sec_tens, sec_ones} != enc(m_min, m_sec)) begin
                n_fail++;
                $display("FAIL %s digits: actual %h expected %h", tag_of(m_mode),
                         {min_tens, min_ones, sec_tens, sec_ones}, enc(m_min, m_sec));
            end
            n_checks++;
            if (alarm_led != (m_mode == 2)) begin
                n_fail++;
                $display("FAIL R6 alarm_led: actual %0b expected %0b", alarm_led, m_mode == 2);
            end
            n_checks++;
            if (tone_out != ((m_mode == 2) && tone_in)) begin
                n_fail++;
                $display("FAIL R7 tone_out: actual %0b expected %0b", tone_out,
                         (m_mode == 2) && tone_in);
            end
        end
    end

    task automatic chk(string tag, logic [16:0] act, logic [16:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [16:0] obs();
        return {alarm_led, min_tens, min_ones, sec_tens, sec_ones};
    endfunction

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ticks(int n);
        repeat (n) begin
            tick_set = 1; cyc(1);
            tick_set = 0; cyc(1);
        end
    endtask

    task automatic run_ticks(int n);
        repeat (n) begin
            tick_run = 1; cyc(1);
            tick_run = 0; cyc(2);
        end
    endtask

    task automatic press_start(int hold);
        btn_start = 1; cyc(hold);
        btn_start = 0; cyc(3);
    endtask

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        chk("R1 reset state", obs(), {1'b0, 16'h0000});
        chk("R1 tone after reset", {16'b0, tone_out}, 17'd0);

        // R2: minutes step up while held, seconds untouched
        set_ticks(2);
        chk("R2 ticks without button", obs(), {1'b0, 16'h0000});
        btn_min = 1; set_ticks(3); btn_min = 0;
        chk("R2 minutes set", obs(), {1'b0, 16'h0300});

        // R3: seconds wrap 59 -> 00 without carry
        btn_sec = 1; set_ticks(59);
        chk("R3 seconds at 59", obs(), {1'b0, 16'h0359});
        set_ticks(1); btn_sec = 0;
        chk("R3 seconds wrap no carry", obs(), {1'b0, 16'h0300});
        btn_min = 1; set_ticks(57); btn_min = 0;
        chk("R2 minutes wrap to 00", obs(), {1'b0, 16'h0000});

        // R4: start at 00:00 is ignored, set buttons still act
        press_start(4);
        run_ticks(2);
        btn_sec = 1; set_ticks(1); btn_sec = 0;
        chk("R4 start at zero ignored", obs(), {1'b0, 16'h0001});

        // Set 01:02
        btn_min = 1; set_ticks(1); btn_min = 0;
        btn_sec = 1; set_ticks(1); btn_sec = 0;
        chk("R2 R3 time 01:02", obs(), {1'b0, 16'h0102});

        // R4 long hold gives one start; R5 countdown with borrow
        press_start(10);
        run_ticks(2);
        chk("R5 countdown", obs(), {1'b0, 16'h0100});
        run_ticks(1);
        chk("R5 borrow to 00:59", obs(), {1'b0, 16'h0059});

        // R5: set buttons, set ticks, start and stop ignored while running
        btn_min = 1; btn_sec = 1; btn_stop = 1; set_ticks(4);
        btn_min = 0; btn_sec = 0; btn_stop = 0;
        press_start(2);
        chk("R5 buttons ignored in run", obs(), {1'b0, 16'h0059});

        // R6: run to zero, alarm one cycle later, no wrap
        run_ticks(58);
        chk("R5 at 00:01", obs(), {1'b0, 16'h0001});
        tick_run = 1; cyc(1); tick_run = 0;
        chk("R6 zero before alarm", obs(), {1'b0, 16'h0000});
        cyc(1);
        chk("R6 alarm raised", obs(), {1'b1, 16'h0000});
        run_ticks(5);
        chk("R6 no wrap below zero", obs(), {1'b1, 16'h0000});

        // R7: tone follows tone_in during alarm
        tone_in = 1; cyc(1);
        chk("R7 tone passes", {16'b0, tone_out}, 17'd1);
        tone_in = 0; cyc(1);
        chk("R7 tone low", {16'b0, tone_out}, 17'd0);
        repeat (6) begin tone_in = ~tone_in; cyc(1); end

        // R8: stop clears alarm, set works again
        btn_stop = 1; cyc(1); btn_stop = 0;
        chk("R8 alarm cleared", obs(), {1'b0, 16'h0000});
        tone_in = 1; cyc(1);
        chk("R7 tone blocked after stop", {16'b0, tone_out}, 17'd0);
        tone_in = 0;
        btn_min = 1; set_ticks(2); btn_min = 0;
        chk("R8 set after stop", obs(), {1'b0, 16'h0200});
        chk("R9 digits BCD", {13'b0, (min_ones <= 4'd9) && (sec_ones <= 4'd9)
                              && (min_tens <= 4'd5) && (sec_tens <= 4'd5), 3'b0},
            {13'b0, 1'b1, 3'b0});

        cyc(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #900000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule